// File: doc/BRIEF.md
# Raster Refresh and Pixel-Write Scheduler

This block keeps a one-bit-per-pixel bitmap of 256 lines by 256 pixels and turns it into a serial binary video stream. Random point plots can be written into the same storage while the picture is being shown. The bitmap is an internal single-port array of 4096 words of 16 bits. Each line occupies 16 consecutive words.

Access to the array is shared in fixed 16-clock slots. A 4-bit phase counter advances on every pixel clock, and a delayed horizontal sync pulse clears it. In each slot the phase counter gives one fixed position to a display fetch and another to a read-modify-write that sets a single pixel bit. The fetched word is then shifted out one pixel per clock.

A point write is offered as a word address and a bit index on a valid/ready handshake. A vertical sync input sends the refresh pointer back to the first word and blanks the output. After reset the block sweeps zeros through the whole array before it starts the display, so the picture starts blank.

Top module: `raster_sched`

## Requirements
- R1: After reset the block spends exactly 4096 clocks writing zero to every word. During that time `wr_ready` and `video` are 0. `wr_ready` is first seen high in the cycle after the 4096th clock edge that follows reset release. Every pixel then reads back as 0.
- R2: The phase counter increments once per clock and wraps from 15 to 0. A clock edge with `hsync` high sets it to 0. The display read of the refresh address happens at phase 3, and the shift register loads the word at phase 8. With `hsync` sampled high at edge E0, bit k of the n-th fetched word is on `video` in the cycle after edge E0+9+16n+k.
- R3: Pixel 16·j+k of line i is bit k of the word at address 16·i+j. Bit 0 goes out first. A stored 1 gives `video` = 1 (beam on) and a stored 0 gives `video` = 0 (beam off).
- R4: The refresh address advances by one at phase 11 of every slot and wraps from 4095 to 0. Horizontal sync does not reset it.
- R5: While `vsync` is high, `video` is 0 and the refresh address is held at 0.
- R6: A request is taken on a clock edge with `wr_valid` and `wr_ready` both high. `wr_ready` is low in the next cycle and stays low until the write-back at phase 15 has finished.
- R7: Address and bit values offered while `wr_ready` is low are not captured. They leave no mark in the bitmap.
- R8: The write-back ORs the selected bit into the word that was read at phase 11. Ones already in that word are kept, several plots into one word accumulate, and plotting the same pixel twice leaves a single 1.
- R9: If horizontal sync arrives after a slot's display read but before its phase-11 step, the next slot fetches and shows that same address again. No word is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Delayed horizontal sync; clears the phase counter |
| vsync | input | 1 | Vertical sync; homes the refresh address and blanks video |
| wr_valid | input | 1 | Point-write request valid |
| wr_ready | output | 1 | Block can take a point write |
| wr_addr | input | 12 | Word address of the pixel (16·line + word in line) |
| wr_bit | input | 4 | Bit index of the pixel in the word |
| video | output | 1 | Serial binary video, 1 = beam on |

## Verification
The hardest situation to reach is a horizontal sync that lands between a slot's display read and its address step. A mis-handled slot only shows up later, as a duplicated or skipped word on the serial stream. The stimulus first aligns the slot with a combined sync edge and then follows one full field of 4097 words, so the bench knows the phase and the refresh address in every cycle. It then raises `hsync` on exactly the edge that sees phase 5 and checks that the interrupted address is shown again. A refused request is provoked the same way: the bench holds `wr_valid` high for one more cycle after the handshake, while the pending write cannot yet have completed.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Bitmap geometry
    localparam int unsigned PIX_PER_WORD   = 16;
    localparam int unsigned WORDS_PER_LINE = 16;
    localparam int unsigned LINE_COUNT     = 256;
    localparam int unsigned SLOT_W         = $clog2(PIX_PER_WORD);

    // Fixed positions inside one 16-clock access slot
    localparam logic [SLOT_W-1:0] PH_FETCH  = SLOT_W'(3);
    localparam logic [SLOT_W-1:0] PH_LOAD   = SLOT_W'(8);
    localparam logic [SLOT_W-1:0] PH_MOD_RD = SLOT_W'(11);
    localparam logic [SLOT_W-1:0] PH_MOD_WR = SLOT_W'(15);

    typedef enum logic {
        TM_SCRUB,
        TM_RUN
    } tm_mode_t;

    typedef struct packed {
        logic fetch;
        logic load;
        logic mod_rd;
        logic mod_wr;
    } slot_ev_t;

    function automatic logic [PIX_PER_WORD-1:0] pix_mask(input logic [SLOT_W-1:0] idx);
        logic [PIX_PER_WORD-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bitmap_ram.sv
module bitmap_ram #(
    parameter int unsigned DEPTH  = 4096,
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    // Single port, registered read; the output holds between reads
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store[addr] <= wdata;
            end else begin
                rdata <= store[addr];
            end
        end
    end

endmodule

// File: rtl/slot_timer.sv
module slot_timer
    import raster_pkg::*;
#(
    parameter int unsigned DEPTH  = 4096,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              vsync,
    output logic [SLOT_W-1:0] phase,
    output slot_ev_t          ev,
    output logic              scrubbing,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic [ADDR_W-1:0] refresh_addr
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    tm_mode_t mode;
    logic     run;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= TM_SCRUB;
            scrub_addr   <= '0;
            phase        <= '0;
            refresh_addr <= '0;
        end else begin
            case (mode)
                TM_SCRUB: begin
                    scrub_addr <= scrub_addr + 1'b1;
                    if (scrub_addr == LAST_ADDR) begin
                        mode <= TM_RUN;
                    end
                end
                default: begin
                    phase <= hsync ? '0 : phase + 1'b1;
                    if (vsync) begin
                        refresh_addr <= '0;
                    end else if (ev.mod_rd) begin
                        refresh_addr <= refresh_addr + 1'b1;
                    end
                end
            endcase
        end
    end

    assign scrubbing = (mode == TM_SCRUB);

    // Slot actions fire only on a running edge that is not a sync edge
    always_comb begin
        run       = !scrubbing && !hsync;
        ev.fetch  = run && (phase == PH_FETCH);
        ev.load   = run && (phase == PH_LOAD);
        ev.mod_rd = run && (phase == PH_MOD_RD);
        ev.mod_wr = run && (phase == PH_MOD_WR);
    end

endmodule

// File: rtl/point_slot.sv
module point_slot #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BIT_W-1:0]  req_bit,
    input  logic              scrubbing,
    input  logic              hsync,
    input  logic              mod_rd,
    input  logic              mod_wr,
    output logic              req_ready,
    output logic              held_valid,
    output logic [ADDR_W-1:0] held_addr,
    output logic [BIT_W-1:0]  held_bit,
    output logic              mod_active
);

    assign req_ready = !held_valid && !scrubbing;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_addr  <= '0;
            held_bit   <= '0;
            mod_active <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                held_valid <= 1'b1;
                held_addr  <= req_addr;
                held_bit   <= req_bit;
            end
            // A sync between the modify read and the write-back drops the
            // half-done cycle; the held request is retried next slot.
            if (hsync) begin
                mod_active <= 1'b0;
            end else if (mod_wr && mod_active) begin
                held_valid <= 1'b0;
                mod_active <= 1'b0;
            end else if (mod_rd && held_valid) begin
                mod_active <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/video_shifter.sv
module video_shifter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] word_in,
    input  logic             blank,
    output logic             pix_out
);

    logic [WIDTH-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= word_in;
        end else begin
            sreg <= {1'b0, sreg[WIDTH-1:1]};
        end
    end

    assign pix_out = sreg[0] && !blank;

endmodule

// File: rtl/raster_sched.sv
module raster_sched
    import raster_pkg::*;
#(
    parameter int unsigned WORDS_PER_LINE_P = raster_pkg::WORDS_PER_LINE,
    parameter int unsigned LINE_COUNT_P     = raster_pkg::LINE_COUNT,
    localparam int unsigned DEPTH  = WORDS_PER_LINE_P * LINE_COUNT_P,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned BIT_W  = SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BIT_W-1:0]  wr_bit,
    output logic              video
);

    logic [SLOT_W-1:0]       phase;
    slot_ev_t                ev;
    logic                    scrubbing;
    logic [ADDR_W-1:0]       scrub_addr;
    logic [ADDR_W-1:0]       refresh_addr;
    logic                    held_valid;
    logic [ADDR_W-1:0]       held_addr;
    logic [BIT_W-1:0]        held_bit;
    logic                    mod_active;
    logic                    ram_en;
    logic                    ram_we;
    logic [ADDR_W-1:0]       ram_addr;
    logic [PIX_PER_WORD-1:0] ram_wdata;
    logic [PIX_PER_WORD-1:0] ram_rdata;

    slot_timer #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .hsync       (hsync),
        .vsync       (vsync),
        .phase       (phase),
        .ev          (ev),
        .scrubbing   (scrubbing),
        .scrub_addr  (scrub_addr),
        .refresh_addr(refresh_addr)
    );

    point_slot #(
        .ADDR_W(ADDR_W),
        .BIT_W (BIT_W)
    ) u_point (
        .clk       (clk),
        .rst       (rst),
        .req_valid (wr_valid),
        .req_addr  (wr_addr),
        .req_bit   (wr_bit),
        .scrubbing (scrubbing),
        .hsync     (hsync),
        .mod_rd    (ev.mod_rd),
        .mod_wr    (ev.mod_wr),
        .req_ready (wr_ready),
        .held_valid(held_valid),
        .held_addr (held_addr),
        .held_bit  (held_bit),
        .mod_active(mod_active)
    );

    // One memory port, granted by slot phase; the scrub sweep owns it first
    always_comb begin
        ram_we = scrubbing || (ev.mod_wr && mod_active);
        ram_en = ram_we || ev.fetch || (ev.mod_rd && held_valid);
        if (scrubbing) begin
            ram_addr = scrub_addr;
        end else if (ev.fetch) begin
            ram_addr = refresh_addr;
        end else begin
            ram_addr = held_addr;
        end
        ram_wdata = scrubbing ? '0 : (ram_rdata | pix_mask(held_bit));
    end

    bitmap_ram #(
        .DEPTH (DEPTH),
        .WIDTH (PIX_PER_WORD),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .en   (ram_en),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    video_shifter #(
        .WIDTH(PIX_PER_WORD)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (ev.load),
        .word_in(ram_rdata),
        .blank  (vsync || scrubbing),
        .pix_out(video)
    );

endmodule

// File: rtl/raster_sched_chk.sv
module raster_sched_chk
    import raster_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BIT_W  = 4,
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              vsync,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [SLOT_W-1:0] phase,
    input logic [ADDR_W-1:0] refresh_addr,
    input logic              scrubbing,
    input logic              ram_we,
    input logic [WORD_W-1:0] ram_wdata,
    input logic [WORD_W-1:0] ram_rdata,
    input logic              held_valid,
    input logic [ADDR_W-1:0] held_addr,
    input logic [BIT_W-1:0]  held_bit,
    input logic              mod_rd
);

    // R6
    ready_drops_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready |=> !wr_ready);

    // R8
    keeps_ones_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we && !scrubbing |-> ((ram_wdata & ram_rdata) == ram_rdata));

    // R2
    wb_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we && !scrubbing |-> phase == PH_MOD_WR);

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        held_valid && $past(held_valid) |-> $stable(held_addr) && $stable(held_bit));

    // R5
    vsync_home_chk: assert property (@(posedge clk) disable iff (rst)
        vsync |=> refresh_addr == '0);

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        mod_rd && !vsync |=> refresh_addr == ADDR_W'($past(refresh_addr) + 1'b1));

endmodule

bind raster_sched raster_sched_chk #(
    .ADDR_W(ADDR_W),
    .BIT_W (BIT_W),
    .WORD_W(raster_pkg::PIX_PER_WORD)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vsync       (vsync),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .phase       (phase),
    .refresh_addr(refresh_addr),
    .scrubbing   (scrubbing),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .ram_rdata   (ram_rdata),
    .held_valid  (held_valid),
    .held_addr   (held_addr),
    .held_bit    (held_bit),
    .mod_rd      (ev.mod_rd)
);

// File: tb/tb_raster_sched.sv
`timescale 1ns/1ps
module tb_raster_sched;

    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [11:0] wr_addr = '0;
    logic [3:0]  wr_bit = '0;
    logic        video;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] model [DEPTH];
    logic [15:0] exp_q [$];
    int          exp_a [$];

    always #2 clk = ~clk;

    raster_sched dut (
        .clk     (clk),
        .rst     (rst),
        .hsync   (hsync),
        .vsync   (vsync),
        .wr_valid(wr_valid),
        .wr_ready(wr_ready),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .video   (video)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one point plot, then a refused request that must not land
    task automatic plot(input int a, input int b);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = 12'(a);
        wr_bit   = 4'(b);
        @(negedge clk);
        chk("R6 ready low after accept", longint'(wr_ready), 0);
        wr_addr = 12'd6;
        wr_bit  = 4'd1;
        @(negedge clk);
        wr_valid = 1'b0;
        model[a][b] = 1'b1;
    endtask

    // Called at a negedge; the next posedge sees the sync levels
    task automatic sync_edge(input logic h, input logic v_during, input logic v_after);
        hsync = h;
        vsync = v_during;
        @(negedge clk);
        hsync = 1'b0;
        vsync = v_after;
    endtask

    // Scoreboard: push expected words, then collect and compare the stream
    task automatic watch(input int first, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[(first + i) % DEPTH]);
            exp_a.push_back((first + i) % DEPTH);
        end
        for (int c = 1; c < 9; c++) @(negedge clk);
        for (int w = 0; w < n; w++) begin
            logic [15:0] got;
            logic [15:0] want;
            int          adr;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                got[k] = video;
            end
            want = exp_q.pop_front();
            adr  = exp_a.pop_front();
            checks++;
            if (got != want) begin
                failures++;
                $display("FAIL %s word %0d actual=%04h expected=%04h", req, adr, got, want);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        int lit;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 ready during clear", longint'(wr_ready), 0);
        chk("R1 video during clear", longint'(video), 0);
        n = 0;
        lit = 0;
        while (!wr_ready) begin
            @(negedge clk);
            n++;
            if (video) lit++;
        end
        chk("R1 clear length", n, 4096);
        chk("R1 video dark while clearing", lit, 0);

        // R8 accumulation, idempotent repeat; corners of the bitmap
        plot(0, 3);
        plot(0, 9);
        plot(0, 9);
        plot(1, 0);
        plot(2, 15);
        plot(5, 7);
        plot(4095, 15);
        plot(4, 4);
        plot(3, 12);
        while (!wr_ready) @(negedge clk);

        // R5: vsync blanks and homes the refresh pointer
        sync_edge(1'b1, 1'b1, 1'b1);
        lit = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (video) lit++;
        end
        chk("R5 video blank under vsync", lit, 0);

        // R2 R3 R4 R7 R8: whole field plus wrap back to word 0
        sync_edge(1'b1, 1'b1, 1'b0);
        watch(0, 4097, "R2/R3/R4/R7/R8 field");

        // R9: hsync seen on the edge at phase 5 of the slot showing word 2
        repeat (13) @(negedge clk);
        sync_edge(1'b1, 1'b0, 1'b0);
        watch(2, 4, "R9 mid-slot hsync");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule